// File: doc/BRIEF.md
# Indexed Byte Access Port with Lockable Windows

This block exposes a byte-wide memory of up to 8K locations through a window of only four I/O offsets. The host first builds a 16-bit location pointer. It does this by writing the pointer's low byte and its high byte at two separate offsets, and either byte can be replaced without disturbing the other. The host then moves data through a third offset. A data write stores the byte at the pointed location and returns the pointer to zero. A data read returns the stored byte and leaves the pointer where it was.

Two 16-byte ranges can each be fenced off by a lock bit. A side-band toggle request flips one lock bit at a time. While a range is locked, reads of it give 0xFF and writes to it never reach the memory. Locations at or beyond the configured memory size behave the same way. The block drives a plain synchronous single-port memory (one cycle read latency) and holds none of the storage itself.

Top module: `idx_port_ctl`

## Requirements
- R1: A write at offset 0 loads the low byte of the pointer and keeps its high byte.
- R2: A write at offset 1 loads the high byte of the pointer and keeps its low byte.
- R3: A write at offset 3 raises `mem_we` in the same cycle with `mem_addr` equal to the pointer and `mem_wdata` equal to the written byte. From the next cycle the pointer is 0x0000. The pointer clears even when the write is discarded.
- R4: A read at offset 3 returns the byte stored at the pointer. The byte appears on `io_rdata` with `io_rvalid` high exactly two clock edges after the request edge, and the pointer is unchanged.
- R5: While lock bit 0 is set, pointers 0x20 to 0x2F are blocked. While lock bit 1 is set, pointers 0x30 to 0x3F are blocked. A blocked read returns 0xFF and a blocked write produces no `mem_we`.
- R6: A `lock_flip` pulse with `lock_sel` = n inverts lock bit n. An access in the same cycle is judged with the lock state from before the flip.
- R7: A pointer at or above MEM_BYTES (the high byte counts) reads 0xFF and its writes produce no `mem_we`.
- R8: Offset 2 is reserved: a write there changes neither the pointer nor the memory. Reads at offsets 0, 1 and 2 return 0xFF with the normal `io_rvalid` timing.
- R9: A synchronous reset clears the pointer and both lock bits, drops `io_rvalid` and sets `io_rdata` to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sel | input | 1 | Access strobe, one cycle per access |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_off | input | 2 | Window offset: 0 pointer low, 1 pointer high, 2 reserved, 3 data |
| io_wdata | input | BYTE_W | Write byte |
| io_rdata | output | BYTE_W | Registered read byte |
| io_rvalid | output | 1 | One-cycle pulse marking `io_rdata` valid |
| lock_flip | input | 1 | Request to invert one lock bit |
| lock_sel | input | SEL_W | Index of the lock bit to invert |
| mem_addr | output | MEM_AW | Memory address (low bits of the pointer) |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | BYTE_W | Memory write byte |
| mem_rdata | input | BYTE_W | Memory read byte, valid one cycle after the address |

## Verification
A corrupted pointer is visible on `mem_addr` at the first sample after the edge that corrupted it, because the memory address is the pointer's low bits. Corruption in the high byte shows up on the next data access as a spurious 0xFF or a missing `mem_we`. A wrong lock bit shows up in one of two ways. A write gives a missing or extra `mem_we` in the same cycle as the request. A read gives a 0xFF instead of data, or data instead of 0xFF, two edges after the request. Sweeping every location both unlocked and under each lock combination therefore exposes any stuck or swapped window boundary within one access.

// File: rtl/idx_port_pkg.sv
package idx_port_pkg;

  // Decoding of the four-byte I/O window.
  typedef enum logic [1:0] {
    OFF_PTR_LO = 2'd0,
    OFF_PTR_HI = 2'd1,
    OFF_RSVD   = 2'd2,
    OFF_DATA   = 2'd3
  } io_off_e;

  // Byte value returned for anything that does not read memory.
  localparam logic [7:0] FILL_BYTE = 8'hFF;

endpackage

// File: rtl/idx_addr_latch.sv
module idx_addr_latch #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  localparam int PTR_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  ld,
  input  logic              clr,
  input  logic [BYTE_W-1:0] din,
  output logic [PTR_W-1:0]  q
);

  logic [BYTE_W-1:0] lane_q [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q[k] <= '0;
      end else if (clr) begin
        lane_q[k] <= '0;
      end else if (ld[k]) begin
        lane_q[k] <= din;
      end
    end

    // R1/R2: a loaded lane takes the presented byte
    p_lane_load_r1: assert property (@(posedge clk) disable iff (rst)
      (ld[k] && !clr) |=> (lane_q[k] == $past(din)));
  end

  always_comb begin
    q = '0;
    for (int k = 0; k < LANES; k++) begin
      q[k*BYTE_W +: BYTE_W] = lane_q[k];
    end
  end

  // R3: a data write leaves a zero pointer
  p_ptr_clear_r3: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0));

endmodule

// File: rtl/idx_lock_guard.sv
module idx_lock_guard #(
  parameter int ADDR_W    = 16,
  parameter int MEM_BYTES = 8192,
  parameter int NUM_LOCKS = 2,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16,
  localparam int SEL_W    = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flip,
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              deny
);

  localparam logic [ADDR_W:0] SIZE_LIM = (ADDR_W+1)'(MEM_BYTES);

  logic [NUM_LOCKS-1:0] lock_q;
  logic [NUM_LOCKS-1:0] flip_mask;
  logic [NUM_LOCKS-1:0] win_hit;
  logic [ADDR_W:0]      addr_x;
  logic                 beyond;

  assign addr_x = {1'b0, addr};

  always_comb begin
    flip_mask = '0;
    for (int n = 0; n < NUM_LOCKS; n++) begin
      flip_mask[n] = flip && (sel == SEL_W'(n));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= '0;
    end else begin
      lock_q <= lock_q ^ flip_mask;
    end
  end

  for (genvar n = 0; n < NUM_LOCKS; n++) begin : g_win
    localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(LOCK_BASE + n * LOCK_SPAN);
    localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(LOCK_BASE + (n + 1) * LOCK_SPAN);
    assign win_hit[n] = lock_q[n] && (addr_x >= WIN_LO) && (addr_x < WIN_HI);
  end

  assign beyond = (addr_x >= SIZE_LIM);
  assign deny   = (|win_hit) || beyond;

  // R6: a flip request changes exactly one lock bit
  p_flip_one_r6: assert property (@(posedge clk) disable iff (rst)
    flip |=> ($countones(lock_q ^ $past(lock_q)) == 1));

  // R6: without a request the locks hold
  p_lock_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !flip |=> $stable(lock_q));

endmodule

// File: rtl/idx_read_pipe.sv
module idx_read_pipe #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic              rd_hit,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [BYTE_W-1:0] io_rdata,
  output logic              io_rvalid
);

  logic pend_q;
  logic hit_q;

  // Stage 1: memory is sampling the address on this same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      pend_q <= rd_req;
      hit_q  <= rd_req && rd_hit;
    end
  end

  // Stage 2: register the returned byte or the fill value.
  always_ff @(posedge clk) begin
    if (rst) begin
      io_rvalid <= 1'b0;
      io_rdata  <= '1;
    end else begin
      io_rvalid <= pend_q;
      if (pend_q) begin
        io_rdata <= hit_q ? mem_rdata : '1;
      end
    end
  end

  // R4: every read request is answered two edges later
  p_rvalid_lat_r4: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> ##1 io_rvalid);

  // R5/R7/R8: a request that misses memory answers all ones
  p_miss_fill_r5: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !hit_q) |=> (io_rvalid && io_rdata == '1));

  // R4: no spurious valid
  p_no_stray_r4: assert property (@(posedge clk) disable iff (rst)
    !pend_q |=> !io_rvalid);

endmodule

// File: rtl/idx_port_ctl.sv
module idx_port_ctl #(
  parameter int BYTE_W     = 8,
  parameter int MEM_BYTES  = 8192,
  parameter int NUM_LOCKS  = 2,
  parameter int LOCK_BASE  = 32,
  parameter int LOCK_SPAN  = 16,
  localparam int PTR_LANES = 2,
  localparam int PTR_W     = BYTE_W * PTR_LANES,
  localparam int MEM_AW    = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1,
  localparam int SEL_W     = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_sel,
  input  logic              io_wr,
  input  logic [1:0]        io_off,
  input  logic [BYTE_W-1:0] io_wdata,
  output logic [BYTE_W-1:0] io_rdata,
  output logic              io_rvalid,
  input  logic              lock_flip,
  input  logic [SEL_W-1:0]  lock_sel,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata
);

  import idx_port_pkg::*;

  io_off_e              off;
  logic                 wr_req;
  logic                 rd_req;
  logic [PTR_LANES-1:0] ptr_ld;
  logic                 data_wr;
  logic [PTR_W-1:0]     ptr_q;
  logic                 deny;
  logic                 rd_hit;

  assign off     = io_off_e'(io_off);
  assign wr_req  = io_sel && io_wr;
  assign rd_req  = io_sel && !io_wr;
  assign data_wr = wr_req && (off == OFF_DATA);

  always_comb begin
    ptr_ld    = '0;
    ptr_ld[0] = wr_req && (off == OFF_PTR_LO);
    ptr_ld[1] = wr_req && (off == OFF_PTR_HI);
  end

  idx_addr_latch #(
    .BYTE_W (BYTE_W),
    .LANES  (PTR_LANES)
  ) u_ptr (
    .clk  (clk),
    .rst  (rst),
    .ld   (ptr_ld),
    .clr  (data_wr),
    .din  (io_wdata),
    .q    (ptr_q)
  );

  idx_lock_guard #(
    .ADDR_W    (PTR_W),
    .MEM_BYTES (MEM_BYTES),
    .NUM_LOCKS (NUM_LOCKS),
    .LOCK_BASE (LOCK_BASE),
    .LOCK_SPAN (LOCK_SPAN)
  ) u_guard (
    .clk  (clk),
    .rst  (rst),
    .flip (lock_flip),
    .sel  (lock_sel),
    .addr (ptr_q),
    .deny (deny)
  );

  assign rd_hit = (off == OFF_DATA) && !deny;

  idx_read_pipe #(
    .BYTE_W (BYTE_W)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .rd_hit    (rd_hit),
    .mem_rdata (mem_rdata),
    .io_rdata  (io_rdata),
    .io_rvalid (io_rvalid)
  );

  assign mem_addr  = ptr_q[MEM_AW-1:0];
  assign mem_we    = data_wr && !deny;
  assign mem_wdata = io_wdata;

  // R3: memory is written only by a data-offset write strobe
  p_we_source_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (io_sel && io_wr && io_off == 2'd3));

  // R4: a read leaves the pointer in place
  p_read_keeps_ptr_r4: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> $stable(mem_addr));

  // R8: reserved-offset writes touch nothing
  p_rsvd_inert_r8: assert property (@(posedge clk) disable iff (rst)
    (io_sel && io_wr && io_off == 2'd2) |-> (!mem_we ##1 $stable(mem_addr)));

  // R9: idle after reset
  p_reset_idle_r9: assert property (@(posedge clk)
    $past(rst) |-> (!io_rvalid && mem_addr == '0));

endmodule

// File: tb/idx_port_ctl_test.sv
module idx_port_ctl_test;

  localparam int MB = 256;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       io_sel = 1'b0;
  logic       io_wr = 1'b0;
  logic [1:0] io_off = 2'd0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic       io_rvalid;
  logic       lock_flip = 1'b0;
  logic [0:0] lock_sel = 1'b0;
  logic [7:0] mem_addr;
  logic       mem_we;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0] ram [MB];
  logic [7:0] shadow [MB];

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  idx_port_ctl #(.BYTE_W(8), .MEM_BYTES(MB)) uut (
    .clk(clk), .rst(rst), .io_sel(io_sel), .io_wr(io_wr), .io_off(io_off),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .lock_flip(lock_flip), .lock_sel(lock_sel), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'((a * 37 + 11 + salt * 101) & 255);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  logic       we_seen;
  logic [7:0] wa_seen;

  task automatic io_write(input logic [1:0] off, input logic [7:0] d);
    @(negedge clk);
    io_sel = 1'b1; io_wr = 1'b1; io_off = off; io_wdata = d;
    #1;
    we_seen = mem_we;
    wa_seen = mem_addr;
    @(negedge clk);
    io_sel = 1'b0; io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [1:0] off, output logic [7:0] d, output logic v);
    @(negedge clk);
    io_sel = 1'b1; io_wr = 1'b0; io_off = off;
    @(negedge clk);
    io_sel = 1'b0;
    @(negedge clk);
    d = io_rdata;
    v = io_rvalid;
  endtask

  task automatic set_ptr(input logic [15:0] p);
    io_write(2'd0, p[7:0]);
    io_write(2'd1, p[15:8]);
  endtask

  task automatic flip_lock(input logic n);
    @(negedge clk);
    lock_flip = 1'b1; lock_sel = n;
    @(negedge clk);
    lock_flip = 1'b0;
  endtask

  function automatic logic locked(input int a, input logic l0, input logic l1);
    return (l0 && a >= 32 && a < 48) || (l1 && a >= 48 && a < 64);
  endfunction

  initial begin
    repeat (1000000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 rvalid", 16'(io_rvalid), 16'h0);
    chk("R9 rdata", 16'(io_rdata), 16'hFF);
    chk("R9 ptr", 16'(mem_addr), 16'h0);

    // R3 sweep: write every location
    for (int a = 0; a < MB; a++) begin
      set_ptr(16'(a));
      io_write(2'd3, pat(a, 0));
      shadow[a] = pat(a, 0);
      chk("R3 we", 16'(we_seen), 16'h1);
      chk("R3 addr", 16'(wa_seen), 16'(a));
      chk("R3 clear", 16'(mem_addr), 16'h0);
    end

    // R4 sweep: read back, pointer kept
    for (int a = 0; a < MB; a++) begin
      set_ptr(16'(a));
      io_read(2'd3, d, v);
      chk("R4 valid", 16'(v), 16'h1);
      chk("R4 data", 16'(d), 16'(shadow[a]));
      chk("R4 ptr kept", 16'(mem_addr), 16'(a));
    end

    // R1/R2: lanes load independently; high byte pushes out of range (R7)
    set_ptr(16'h0011);
    io_write(2'd1, 8'h01);
    chk("R2 low kept", 16'(mem_addr), 16'h11);
    io_write(2'd0, 8'h44);
    chk("R1 low load", 16'(mem_addr), 16'h44);
    io_read(2'd3, d, v);
    chk("R1 high kept", 16'(d), 16'hFF);
    io_write(2'd1, 8'h00);
    chk("R2 low kept2", 16'(mem_addr), 16'h44);
    io_read(2'd3, d, v);
    chk("R2 high load", 16'(d), 16'(shadow[8'h44]));

    // R7: out-of-range pointers for several high bytes
    for (int h = 1; h < 256; h += 37) begin
      set_ptr({8'(h), 8'h5A});
      io_read(2'd3, d, v);
      chk("R7 read ff", 16'(d), 16'hFF);
      io_write(2'd3, 8'h00);
      chk("R7 no we", 16'(we_seen), 16'h0);
      chk("R3 clear after discard", 16'(mem_addr), 16'h0);
    end
    set_ptr(16'h005A);
    io_read(2'd3, d, v);
    chk("R7 mem untouched", 16'(d), 16'(shadow[8'h5A]));

    // R8: reserved offset and non-data reads
    set_ptr(16'h0077);
    io_write(2'd2, 8'h99);
    chk("R8 no we", 16'(we_seen), 16'h0);
    chk("R8 ptr kept", 16'(mem_addr), 16'h77);
    for (int o = 0; o < 3; o++) begin
      io_read(2'(o), d, v);
      chk("R8 valid", 16'(v), 16'h1);
      chk("R8 ff", 16'(d), 16'hFF);
    end

    // R5/R6: sweep under each lock combination
    for (int st = 1; st < 4; st++) begin
      logic l0, l1;
      if (st == 1) flip_lock(1'b0);
      if (st == 2) flip_lock(1'b1);
      if (st == 3) flip_lock(1'b0);
      l0 = (st == 1 || st == 2);
      l1 = (st == 2 || st == 3);
      for (int a = 0; a < 80; a++) begin
        set_ptr(16'(a));
        io_read(2'd3, d, v);
        chk(locked(a, l0, l1) ? "R5 blocked read" : "R6 open read",
            16'(d), locked(a, l0, l1) ? 16'hFF : 16'(shadow[a]));
        set_ptr(16'(a));
        io_write(2'd3, pat(a, st));
        chk("R5 write gate", 16'(we_seen), locked(a, l0, l1) ? 16'h0 : 16'h1);
        if (!locked(a, l0, l1)) shadow[a] = pat(a, st);
      end
    end

    // R6: flip in the same cycle as a read uses the old state (lock1 set)
    set_ptr(16'h0035);
    @(negedge clk);
    lock_flip = 1'b1; lock_sel = 1'b1;
    io_sel = 1'b1; io_wr = 1'b0; io_off = 2'd3;
    @(negedge clk);
    lock_flip = 1'b0; io_sel = 1'b0;
    @(negedge clk);
    chk("R6 old state", 16'(io_rdata), 16'hFF);
    io_read(2'd3, d, v);
    chk("R6 after flip", 16'(d), 16'(shadow[8'h35]));

    // R9: reset mid-run clears locks and pointer
    flip_lock(1'b0);
    set_ptr(16'h0025);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 ptr cleared", 16'(mem_addr), 16'h0);
    chk("R9 rvalid low", 16'(io_rvalid), 16'h0);
    set_ptr(16'h0025);
    io_read(2'd3, d, v);
    chk("R9 lock cleared", 16'(d), 16'(shadow[8'h25]));

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule